// File: doc/BRIEF.md
# Matrix Key Event Filter

This block turns one snapshot of a scanned key matrix into an ordered stream of key events. A snapshot is a fixed set of entry slots; each slot carries a valid bit, a row index and a column index. When the block is started, it forms a scan code for every valid slot. An optional function-key page is supported: one configured scan code acts as a page shift and is removed from the snapshot, and every other code moves into the upper keymap page. The block then screens the snapshot for the phantom keys that a diode-less matrix produces when three keys close a rectangle.

A snapshot that passes the screen is compared with the set of keys accepted last time. A release event goes out for every held key that has disappeared. A press event then goes out for every key in the new snapshot. The new snapshot becomes the held set. A snapshot that fails the screen produces no events at all and leaves the held set untouched. Events leave one at a time through a valid/ready handshake. A one-cycle done pulse closes each run, with a reject flag beside it when the snapshot was screened out.

Top module: `keyev_filter`

## Requirements
- R1: After reset the block is idle. No event is offered, done and rejected are low, and held_count is 0.
- R2: The scan code of a slot is its row shifted left by log2(COLS) bits, ORed with its column. With the defaults this is row*8+col. When no page shift is active, the event code is this scan code, with a zero upper bit.
- R3: With fn_mode_en high, a valid slot whose scan code equals fn_code is neither counted nor reported. If such a slot is present, ROWS*COLS (128 by default) is added to the code of every other kept slot. With fn_mode_en low, that slot is an ordinary key.
- R4: Suppose ghost_en is high and at least three keys are kept. If some pair of kept keys shares a column, and some pair of kept keys shares a row, the snapshot is rejected. No event is offered, and done rises together with rejected.
- R5: No rejection happens when ghost_en is low or when fewer than three keys are kept. This holds even if keys share rows and columns.
- R6: A rejected snapshot leaves the held set and held_count unchanged.
- R7: For every held key whose code is not among the new kept codes, a release event (ev_press=0) is offered. These events come in ascending order of the held key's slot, and all of them come before any press event.
- R8: After the releases, one press event (ev_press=1) is offered for every kept slot, in ascending slot order. This includes keys that were already held.
- R9: After an accepted run, the held set becomes the new kept set, and held_count equals its size. The update is visible in the cycle after done.
- R10: A snapshot with no kept keys releases every held key and leaves held_count at 0.
- R11: An offered event keeps its code and kind while ev_ready is low. It is consumed on the clock edge where ev_valid and ev_ready are both high. At most one event is consumed per clock.
- R12: start is ignored while busy is high, and changes to the snapshot inputs during a run do not affect it. done is a single-cycle pulse, and busy falls in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing the present snapshot |
| ghost_en | input | 1 | Enable the phantom-key screen |
| fn_mode_en | input | 1 | Enable the function-key page shift |
| fn_code | input | 7 | Scan code of the page-shift key |
| slot_valid | input | 8 | Valid bit per snapshot slot |
| slot_row | input | 32 | Row index per slot, 4 bits each, slot 0 lowest |
| slot_col | input | 24 | Column index per slot, 3 bits each, slot 0 lowest |
| ev_ready | input | 1 | Consumer accepts the offered event |
| ev_valid | output | 1 | An event is offered |
| ev_press | output | 1 | 1 for a press event, 0 for a release event |
| ev_code | output | 8 | Key code of the offered event |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| rejected | output | 1 | Set with done when the snapshot was screened out |
| held_count | output | 4 | Number of keys in the held set |

## Verification
The assertions assume that every row index is below ROWS and every column index is below COLS. They also assume that the consumer may drop ev_ready at any time. All stimulus draws rows and columns from those ranges. Some runs confine the indices to a two-by-two corner so that rejections are frequent. The ready pattern is varied from run to run. A new start is also pulsed in the middle of a run, with the snapshot inputs scrambled, so that the one-run-at-a-time behaviour is exercised without breaking the checker's premises.

// File: rtl/keyev_pkg.sv
package keyev_pkg;

    localparam int unsigned KE_ROWS  = 16;
    localparam int unsigned KE_COLS  = 8;
    localparam int unsigned KE_SLOTS = 8;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_RELEASE = 2'd1,
        PH_PRESS   = 2'd2,
        PH_FINISH  = 2'd3
    } phase_e;

    // Index width that stays at least one bit wide
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/keyev_snapshot.sv
module keyev_snapshot #(
    parameter int unsigned ROWS  = keyev_pkg::KE_ROWS,
    parameter int unsigned COLS  = keyev_pkg::KE_COLS,
    parameter int unsigned SLOTS = keyev_pkg::KE_SLOTS,
    localparam int unsigned RW     = keyev_pkg::idx_bits(ROWS),
    localparam int unsigned CW     = keyev_pkg::idx_bits(COLS),
    localparam int unsigned SCAN_W = RW + CW,
    localparam int unsigned CODE_W = SCAN_W + 1,
    localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0]        slot_valid,
    input  logic [SLOTS*RW-1:0]     slot_row,
    input  logic [SLOTS*CW-1:0]     slot_col,
    input  logic                    fn_mode_en,
    input  logic [SCAN_W-1:0]       fn_code,
    output logic [SLOTS-1:0]        keep,
    output logic [SLOTS*CODE_W-1:0] code,
    output logic [CNT_W-1:0]        keep_cnt
);

    localparam logic [CODE_W-1:0] PAGE_OFS = CODE_W'(ROWS * COLS);

    logic [SLOTS-1:0] is_fn;
    logic             fn_seen;

    assign fn_seen = |is_fn;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [SCAN_W-1:0] scan;
        assign scan     = {slot_row[g*RW +: RW], slot_col[g*CW +: CW]};
        assign is_fn[g] = slot_valid[g] && fn_mode_en && (scan == fn_code);
        assign keep[g]  = slot_valid[g] && !is_fn[g];
        assign code[g*CODE_W +: CODE_W] =
            {1'b0, scan} + (fn_seen ? PAGE_OFS : '0);
    end

    always_comb begin
        keep_cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            keep_cnt = keep_cnt + CNT_W'(keep[i]);
        end
    end

endmodule

// File: rtl/keyev_ghost.sv
module keyev_ghost #(
    parameter int unsigned SLOTS = keyev_pkg::KE_SLOTS,
    parameter int unsigned RW    = 4,
    parameter int unsigned CW    = 3,
    localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                ghost_en,
    input  logic [SLOTS-1:0]    keep,
    input  logic [CNT_W-1:0]    keep_cnt,
    input  logic [SLOTS*RW-1:0] slot_row,
    input  logic [SLOTS*CW-1:0] slot_col,
    output logic                ghost
);

    localparam logic [CNT_W-1:0] MIN_KEYS = CNT_W'(3);

    logic row_pair;
    logic col_pair;

    always_comb begin
        row_pair = 1'b0;
        col_pair = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            for (int j = i + 1; j < SLOTS; j++) begin
                if (keep[i] && keep[j]) begin
                    if (slot_row[i*RW +: RW] == slot_row[j*RW +: RW]) row_pair = 1'b1;
                    if (slot_col[i*CW +: CW] == slot_col[j*CW +: CW]) col_pair = 1'b1;
                end
            end
        end
    end

    assign ghost = ghost_en && (keep_cnt >= MIN_KEYS) && row_pair && col_pair;

endmodule

// File: rtl/keyev_seq.sv
module keyev_seq #(
    parameter int unsigned SLOTS  = keyev_pkg::KE_SLOTS,
    parameter int unsigned CODE_W = 8,
    localparam int unsigned CNT_W = $clog2(SLOTS + 1),
    localparam int unsigned IDX_W = keyev_pkg::idx_bits(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    ghost,
    input  logic [SLOTS-1:0]        keep,
    input  logic [SLOTS*CODE_W-1:0] code,
    input  logic                    ev_ready,
    output logic                    ev_valid,
    output logic                    ev_press,
    output logic [CODE_W-1:0]       ev_code,
    output logic                    busy,
    output logic                    done,
    output logic                    rejected,
    output logic [CNT_W-1:0]        held_count
);

    import keyev_pkg::*;

    phase_e                  phase;
    logic [SLOTS-1:0]        held_mask;
    logic [SLOTS*CODE_W-1:0] held_code;
    logic [SLOTS-1:0]        next_mask;
    logic [SLOTS*CODE_W-1:0] next_code;
    logic [SLOTS-1:0]        rel_pend;
    logic [SLOTS-1:0]        prs_pend;
    logic                    rej_q;
    logic [SLOTS-1:0]        gone;
    logic [IDX_W-1:0]        rel_idx;
    logic [IDX_W-1:0]        prs_idx;
    logic                    take;

    // Held keys that are absent from the incoming kept set
    always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
            logic hit;
            hit = 1'b0;
            for (int i = 0; i < SLOTS; i++) begin
                if (keep[i] && (code[i*CODE_W +: CODE_W] == held_code[j*CODE_W +: CODE_W]))
                    hit = 1'b1;
            end
            gone[j] = held_mask[j] && !hit;
        end
    end

    // Lowest pending slot in each phase
    always_comb begin
        rel_idx = '0;
        prs_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (rel_pend[i]) rel_idx = IDX_W'(i);
            if (prs_pend[i]) prs_idx = IDX_W'(i);
        end
    end

    assign ev_valid = ((phase == PH_RELEASE) && (rel_pend != '0)) ||
                      ((phase == PH_PRESS)   && (prs_pend != '0));
    assign ev_press = (phase == PH_PRESS);
    assign ev_code  = (phase == PH_RELEASE) ? held_code[rel_idx*CODE_W +: CODE_W]
                                            : next_code[prs_idx*CODE_W +: CODE_W];
    assign take     = ev_valid && ev_ready;
    assign busy     = (phase != PH_IDLE);
    assign done     = (phase == PH_FINISH);
    assign rejected = done && rej_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            held_mask <= '0;
            held_code <= '0;
            next_mask <= '0;
            next_code <= '0;
            rel_pend  <= '0;
            prs_pend  <= '0;
            rej_q     <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        next_mask <= keep;
                        next_code <= code;
                        if (ghost) begin
                            rej_q    <= 1'b1;
                            rel_pend <= '0;
                            prs_pend <= '0;
                            phase    <= PH_FINISH;
                        end else begin
                            rej_q    <= 1'b0;
                            rel_pend <= gone;
                            prs_pend <= keep;
                            phase    <= PH_RELEASE;
                        end
                    end
                end
                PH_RELEASE: begin
                    if (rel_pend == '0) phase <= PH_PRESS;
                    else if (take) rel_pend <= rel_pend & (rel_pend - 1'b1);
                end
                PH_PRESS: begin
                    if (prs_pend == '0) phase <= PH_FINISH;
                    else if (take) prs_pend <= prs_pend & (prs_pend - 1'b1);
                end
                PH_FINISH: begin
                    if (!rej_q) begin
                        held_mask <= next_mask;
                        held_code <= next_code;
                    end
                    rej_q <= 1'b0;
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        held_count = '0;
        for (int i = 0; i < SLOTS; i++) begin
            held_count = held_count + CNT_W'(held_mask[i]);
        end
    end

endmodule

// File: rtl/keyev_filter.sv
module keyev_filter #(
    parameter int unsigned ROWS  = keyev_pkg::KE_ROWS,
    parameter int unsigned COLS  = keyev_pkg::KE_COLS,
    parameter int unsigned SLOTS = keyev_pkg::KE_SLOTS,
    localparam int unsigned RW     = keyev_pkg::idx_bits(ROWS),
    localparam int unsigned CW     = keyev_pkg::idx_bits(COLS),
    localparam int unsigned SCAN_W = RW + CW,
    localparam int unsigned CODE_W = SCAN_W + 1,
    localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                ghost_en,
    input  logic                fn_mode_en,
    input  logic [SCAN_W-1:0]   fn_code,
    input  logic [SLOTS-1:0]    slot_valid,
    input  logic [SLOTS*RW-1:0] slot_row,
    input  logic [SLOTS*CW-1:0] slot_col,
    input  logic                ev_ready,
    output logic                ev_valid,
    output logic                ev_press,
    output logic [CODE_W-1:0]   ev_code,
    output logic                busy,
    output logic                done,
    output logic                rejected,
    output logic [CNT_W-1:0]    held_count
);

    logic [SLOTS-1:0]        keep;
    logic [SLOTS*CODE_W-1:0] code;
    logic [CNT_W-1:0]        keep_cnt;
    logic                    ghost;

    keyev_snapshot #(.ROWS(ROWS), .COLS(COLS), .SLOTS(SLOTS)) u_snap (
        .slot_valid (slot_valid),
        .slot_row   (slot_row),
        .slot_col   (slot_col),
        .fn_mode_en (fn_mode_en),
        .fn_code    (fn_code),
        .keep       (keep),
        .code       (code),
        .keep_cnt   (keep_cnt)
    );

    keyev_ghost #(.SLOTS(SLOTS), .RW(RW), .CW(CW)) u_ghost (
        .ghost_en (ghost_en),
        .keep     (keep),
        .keep_cnt (keep_cnt),
        .slot_row (slot_row),
        .slot_col (slot_col),
        .ghost    (ghost)
    );

    keyev_seq #(.SLOTS(SLOTS), .CODE_W(CODE_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ghost      (ghost),
        .keep       (keep),
        .code       (code),
        .ev_ready   (ev_ready),
        .ev_valid   (ev_valid),
        .ev_press   (ev_press),
        .ev_code    (ev_code),
        .busy       (busy),
        .done       (done),
        .rejected   (rejected),
        .held_count (held_count)
    );

endmodule

// File: rtl/keyev_filter_chk.sv
module keyev_filter_chk #(
    parameter int unsigned SLOTS  = keyev_pkg::KE_SLOTS,
    parameter int unsigned CODE_W = 8,
    localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_ready,
    input logic              ev_valid,
    input logic              ev_press,
    input logic [CODE_W-1:0] ev_code,
    input logic              busy,
    input logic              done,
    input logic              rejected,
    input logic [CNT_W-1:0]  held_count
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy && !ev_valid && !done && held_count == '0));

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_code) && $stable(ev_press)));

    // R11
    offer_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> busy);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R4
    reject_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        rejected |-> (done && !ev_valid));

    // R6
    reject_keeps_set_chk: assert property (@(posedge clk) disable iff (rst)
        (done && rejected) |=> $stable(held_count));

    // R7
    release_first_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_press) |=> !(ev_valid && !ev_press));

    // R9
    held_bound_chk: assert property (@(posedge clk) disable iff (rst)
        held_count <= CNT_W'(SLOTS));

endmodule

bind keyev_filter keyev_filter_chk #(.SLOTS(SLOTS), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ev_ready   (ev_ready),
    .ev_valid   (ev_valid),
    .ev_press   (ev_press),
    .ev_code    (ev_code),
    .busy       (busy),
    .done       (done),
    .rejected   (rejected),
    .held_count (held_count)
);

// File: tb/keyev_filter_tb.sv
module keyev_filter_tb;

    localparam int ROWS = 16, COLS = 8, SLOTS = 8;
    localparam int RW = 4, CW = 3, SCAN_W = 7, CODE_W = 8, CNT_W = 4;
    localparam int FN_SCAN = 127;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                rst, start, ghost_en, fn_mode_en, ev_ready;
    logic [SCAN_W-1:0]   fn_code;
    logic [SLOTS-1:0]    slot_valid;
    logic [SLOTS*RW-1:0] slot_row;
    logic [SLOTS*CW-1:0] slot_col;
    logic                ev_valid, ev_press, busy, done, rejected;
    logic [CODE_W-1:0]   ev_code;
    logic [CNT_W-1:0]    held_count;

    keyev_filter #(.ROWS(ROWS), .COLS(COLS), .SLOTS(SLOTS)) u_dut (
        .clk(clk), .rst(rst), .start(start), .ghost_en(ghost_en),
        .fn_mode_en(fn_mode_en), .fn_code(fn_code), .slot_valid(slot_valid),
        .slot_row(slot_row), .slot_col(slot_col), .ev_ready(ev_ready),
        .ev_valid(ev_valid), .ev_press(ev_press), .ev_code(ev_code),
        .busy(busy), .done(done), .rejected(rejected), .held_count(held_count)
    );

    int errors = 0;
    int checks = 0;
    int total_cycles = 0;
    int unsigned seed = 32'h1234_5678;

    // stimulus and model state
    bit sv [SLOTS];
    int sr [SLOTS];
    int sc [SLOTS];
    bit hv [SLOTS];
    int hc [SLOTS];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    always @(posedge clk) begin
        total_cycles++;
        if (total_cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", total_cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // Runs one snapshot from sv/sr/sc and checks the outcome against the model
    task automatic run_snap(input bit gen, input bit fmode, input int rmode, input bit poke);
        bit kept [SLOTS];
        int kc [SLOTS];
        int nk = 0;
        bit fnp = 0;
        bit rowp = 0, colp = 0, gh = 0;
        int ec [64];
        bit ep [64];
        int en = 0;
        int gc [64];
        bit gp [64];
        int gn = 0;
        bit grej = 0;
        bit seen = 0;
        int cnt;
        for (int i = 0; i < SLOTS; i++) begin
            int s = sr[i] * COLS + sc[i];
            bit f = sv[i] && fmode && (s == FN_SCAN);
            if (f) fnp = 1;
            kept[i] = sv[i] && !f;
            if (kept[i]) nk++;
        end
        for (int i = 0; i < SLOTS; i++)
            kc[i] = sr[i] * COLS + sc[i] + (fnp ? ROWS * COLS : 0);
        for (int i = 0; i < SLOTS; i++)
            for (int j = i + 1; j < SLOTS; j++)
                if (kept[i] && kept[j]) begin
                    if (sr[i] == sr[j]) rowp = 1;
                    if (sc[i] == sc[j]) colp = 1;
                end
        gh = gen && nk >= 3 && rowp && colp;
        if (!gh) begin
            for (int j = 0; j < SLOTS; j++) begin
                bit found = 0;
                for (int i = 0; i < SLOTS; i++)
                    if (kept[i] && kc[i] == hc[j]) found = 1;
                if (hv[j] && !found) begin ec[en] = hc[j]; ep[en] = 0; en++; end
            end
            for (int i = 0; i < SLOTS; i++)
                if (kept[i]) begin ec[en] = kc[i]; ep[en] = 1; en++; end
        end

        @(negedge clk);
        ghost_en   = gen;
        fn_mode_en = fmode;
        for (int i = 0; i < SLOTS; i++) begin
            slot_valid[i]          = sv[i];
            slot_row[i*RW +: RW]   = RW'(sr[i]);
            slot_col[i*CW +: CW]   = CW'(sc[i]);
        end
        start    = 1'b1;
        ev_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 300; cyc++) begin
            start = 1'b0;
            case (rmode)
                0: ev_ready = 1'b1;
                1: ev_ready = (cyc % 3) != 1;
                default: ev_ready = (cyc % 4) >= 2;
            endcase
            #1;
            if (poke && cyc == 0 && busy) begin
                // R12: a second start and new inputs mid-run must be ignored
                start      = 1'b1;
                slot_valid = ~slot_valid;
                slot_row   = ~slot_row;
            end
            if (ev_valid && ev_ready && gn < 64) begin
                gc[gn] = ev_code; gp[gn] = ev_press; gn++;
            end
            if (done) begin grej = rejected; seen = 1; break; end
            @(negedge clk);
        end
        chk(seen, "R12 run end", int'(seen), 1);
        @(negedge clk);
        start = 1'b0;
        chk(gn == en, "R11 event count", gn, en);
        for (int k = 0; k < en && k < gn; k++) begin
            chk(gc[k] == ec[k], ep[k] ? "R8 press code" : "R7 release code", gc[k], ec[k]);
            chk(gp[k] == ep[k], "R7 event kind order", int'(gp[k]), int'(ep[k]));
        end
        chk(grej == gh, "R4 reject flag", int'(grej), int'(gh));
        chk(!done && !busy, "R12 done single pulse", int'(done), 0);
        if (!gh) begin
            for (int i = 0; i < SLOTS; i++) begin hv[i] = kept[i]; hc[i] = kc[i]; end
        end
        cnt = 0;
        for (int i = 0; i < SLOTS; i++) if (hv[i]) cnt++;
        chk(int'(held_count) == cnt, gh ? "R6 held after reject" : "R9 held count", int'(held_count), cnt);
    endtask

    task automatic clear_snap();
        for (int i = 0; i < SLOTS; i++) begin sv[i] = 0; sr[i] = 0; sc[i] = 0; end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; ghost_en = 1'b1; fn_mode_en = 1'b0; ev_ready = 1'b0;
        fn_code = SCAN_W'(FN_SCAN); slot_valid = '0; slot_row = '0; slot_col = '0;
        for (int i = 0; i < SLOTS; i++) begin hv[i] = 0; hc[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!busy && !ev_valid && !done && !rejected, "R1 idle after reset", int'(busy), 0);
        chk(held_count == '0, "R1 held count zero", int'(held_count), 0);

        // R2: single key, row 2 column 5 -> code 21
        clear_snap(); sv[3] = 1; sr[3] = 2; sc[3] = 5;
        run_snap(1, 0, 0, 0);
        // R10: empty snapshot releases everything
        clear_snap();
        run_snap(1, 0, 1, 0);
        // R3: page key present with page mode on
        clear_snap(); sv[0] = 1; sr[0] = 15; sc[0] = 7; sv[2] = 1; sr[2] = 1; sc[2] = 0;
        run_snap(1, 1, 0, 0);
        // R3: same snapshot, page mode off -> ordinary key
        run_snap(1, 0, 2, 0);
        // R7: held {a,b} -> new {b,c}
        clear_snap(); sv[1] = 1; sr[1] = 3; sc[1] = 1; sv[4] = 1; sr[4] = 5; sc[4] = 2;
        run_snap(1, 0, 0, 0);
        clear_snap(); sv[0] = 1; sr[0] = 5; sc[0] = 2; sv[6] = 1; sr[6] = 9; sc[6] = 6;
        run_snap(1, 0, 1, 0);
        // R4 and R6: rectangle corner of three keys
        clear_snap(); sv[0] = 1; sv[1] = 1; sr[1] = 0; sc[1] = 1; sv[5] = 1; sr[5] = 1; sc[5] = 0;
        run_snap(1, 0, 0, 1);
        // R5: screen off, same keys accepted
        run_snap(0, 0, 0, 0);
        // R5: two keys sharing row and column is not enough
        clear_snap(); sv[2] = 1; sr[2] = 4; sc[2] = 4; sv[7] = 1; sr[7] = 4; sc[7] = 4;
        run_snap(1, 0, 2, 0);

        // Sweep over generated snapshots
        for (int it = 0; it < 400; it++) begin
            int mode = int'(rnd() % 4);
            for (int i = 0; i < SLOTS; i++) begin
                sv[i] = (mode == 3) ? ((rnd() % 4) == 0) : ((rnd() % 2) == 0);
                if (mode == 1 || mode == 2) begin
                    sr[i] = int'(rnd() % 2); sc[i] = int'(rnd() % 2);
                end else begin
                    sr[i] = int'(rnd() % ROWS); sc[i] = int'(rnd() % COLS);
                end
            end
            if (mode == 2) begin
                int p = int'(rnd() % SLOTS);
                sv[p] = 1; sr[p] = 15; sc[p] = 7;
            end
            run_snap((rnd() % 5) != 0, (rnd() % 2) == 0, int'(rnd() % 3), (it % 5) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule